// File: doc/BRIEF.md
# SPI transmit/receive byte queues with threshold flags

This block holds the two data queues of a serial peripheral: a transmit queue that the host fills and the shift engine drains one byte at a time, and a receive queue that the shift engine fills one byte at a time and the host drains. Each queue is eight bytes deep. The host works in 8-bit or 16-bit data mode (`cfg_wide`). A 16-bit access moves two bytes at once. Four status flags report on the queues: transmit full, transmit nearly empty, receive nearly full and receive empty. The two "nearly" flags compare against a threshold counted in bytes. A select bit picks one of two thresholds for each flag. Because the threshold is counted in bytes, the same setting means a different number of host accesses in 8-bit and 16-bit mode.

A small controller follows the three configuration inputs: serial mode, queue enable and peripheral enable. Any change on any of them flushes both queues at the next clock edge. The controller has three states. `ST_POR` is entered from reset. `ST_BYPASS` means queue mode is off after a flush. `ST_ACTIVE` means queue mode is on after a flush. Every state moves on a configuration change (flush):
- From `ST_POR`, a flush goes to `ST_ACTIVE` when the queue enable is 1 and to `ST_BYPASS` otherwise.
- From `ST_BYPASS`, a flush with the queue enable set goes to `ST_ACTIVE`.
- From `ST_ACTIVE`, a flush with the queue enable clear goes to `ST_BYPASS`.
- Any other flush leaves the state where it is.

The flags are live only in `ST_ACTIVE`. In `ST_POR` and `ST_BYPASS` all four flags are held at 0.

Top module: `spi_fifo_pair`

## Requirements
- R1: In `ST_ACTIVE`, `tx_full` is 1 exactly when the transmit queue holds 8 bytes.
- R2: In `ST_ACTIVE`, `rx_near_full` is 1 when the receive queue holds at least 6 bytes with `rx_thr_sel`=0, or at least 4 bytes with `rx_thr_sel`=1. It is 0 otherwise.
- R3: In `ST_ACTIVE`, `tx_near_empty` is 1 when the transmit queue holds at most 2 bytes with `tx_thr_sel`=0, or at most 4 bytes with `tx_thr_sel`=1. It is 0 otherwise.
- R4: In `ST_ACTIVE`, `rx_empty` is 1 exactly when the receive queue holds no bytes. A host read pops one entry:
  - In 8-bit mode it pops one byte, and `host_rdata` shows that byte in bits 7:0 with bits 15:8 at 0.
  - In 16-bit mode it pops two bytes, and `host_rdata` shows the older byte in bits 15:8 and the newer byte in bits 7:0.
- R5: An 8-bit host write queues `host_wdata[7:0]`. A 16-bit host write queues `host_wdata[15:8]` first and then `host_wdata[7:0]`. The engine sees the oldest byte on `eng_tx_data` and removes it with `eng_tx_pop`.
- R6: After reset, all four flags and `rx_overrun` are 0.
- R7: A change on `cfg_spi_mode`, `cfg_fifo_en` or `cfg_periph_en` empties both queues at the next clock edge. Data pushed before the change is never delivered.
- R8: After a configuration flush with `cfg_fifo_en`=1, `tx_near_empty` and `rx_empty` read 1 and the other two flags read 0. With `cfg_fifo_en`=0, all four flags stay 0 whatever the queues hold.
- R9: An engine push into a full receive queue is dropped. It raises `rx_overrun` for exactly the one following cycle.
- R10: A host write that does not fit in the free transmit space is ignored. A host read asking for more bytes than the receive queue holds is ignored and pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_spi_mode | input | 1 | Serial mode setting; a change flushes the queues |
| cfg_fifo_en | input | 1 | Queue mode enable; a change flushes the queues |
| cfg_periph_en | input | 1 | Peripheral enable; a change flushes the queues |
| cfg_wide | input | 1 | 1 = 16-bit host accesses, 0 = 8-bit |
| rx_thr_sel | input | 1 | Receive nearly-full threshold select |
| tx_thr_sel | input | 1 | Transmit nearly-empty threshold select |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe from the receive queue |
| host_rdata | output | 16 | Oldest receive data, formatted by data mode |
| eng_tx_pop | input | 1 | Engine removes one transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_push | input | 1 | Engine adds one received byte |
| eng_rx_data | input | 8 | Received byte |
| rx_overrun | output | 1 | One-cycle pulse after a dropped receive push |
| tx_full | output | 1 | Transmit queue full flag |
| tx_near_empty | output | 1 | Transmit queue nearly empty flag |
| rx_near_full | output | 1 | Receive queue nearly full flag |
| rx_empty | output | 1 | Receive queue empty flag |

## Verification
The bench builds the block with its default parameters: 8-byte queues, a receive nearly-full threshold of 6 or 4 bytes, and a transmit nearly-empty threshold of 2 or 4 bytes. With these values a few host or engine accesses bring each flag to both of its edges in either data mode, and eight pushes reach the full and overrun cases. Flipping a select bit while the queue sits between the two thresholds shows that the flags follow the select bit. Word accesses are mixed with odd byte counts, which exposes a 16-bit read that is refused when only one byte is left.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    typedef enum logic [1:0] {
        ST_POR    = 2'd0,
        ST_BYPASS = 2'd1,
        ST_ACTIVE = 2'd2
    } fifo_state_e;

    typedef struct packed {
        logic spi_mode;
        logic fifo_en;
        logic periph_en;
    } spi_cfg_t;

endpackage

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
    import spi_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  spi_cfg_t    cfg,
    output logic        flush,
    output logic        flags_live,
    output fifo_state_e state
);

    spi_cfg_t    cfg_q;
    fifo_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_POR;
            cfg_q <= '0;
        end else begin
            state <= state_d;
            cfg_q <= cfg;
        end
    end

    always_comb flush = (cfg != cfg_q);

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_POR:    if (flush) state_d = cfg.fifo_en ? ST_ACTIVE : ST_BYPASS;
            ST_BYPASS: if (flush && cfg.fifo_en) state_d = ST_ACTIVE;
            ST_ACTIVE: if (flush && !cfg.fifo_en) state_d = ST_BYPASS;
            default:   state_d = ST_POR;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ACTIVE: flags_live = 1'b1;
            default:   flags_live = 1'b0;
        endcase
    end

    // R8
    state_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((state == ST_ACTIVE) == $past(cfg.fifo_en)));

endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    push_n,
    input  logic [7:0]    push_b0,
    input  logic [7:0]    push_b1,
    input  logic [1:0]    pop_n,
    output logic [7:0]    head0,
    output logic [7:0]    head1,
    output logic [CW-1:0] count
);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;

    always_comb wr_ptr = rd_ptr + count[PW-1:0];

    always_ff @(posedge clk) begin
        if (!flush) begin
            if (push_n != 2'd0) mem[wr_ptr] <= push_b0;
            if (push_n == 2'd2) mem[wr_ptr + PW'(1)] <= push_b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            rd_ptr <= rd_ptr + PW'(pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    always_comb begin
        head0 = mem[rd_ptr];
        head1 = mem[rd_ptr + PW'(1)];
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags #(
    parameter int DEPTH        = 8,
    parameter int RX_NF_SEL0   = 6,
    parameter int RX_NF_SEL1   = 4,
    parameter int TX_NE_SEL0   = 2,
    parameter int TX_NE_SEL1   = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          live,
    input  logic          rx_thr_sel,
    input  logic          tx_thr_sel,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_count,
    output logic          tx_full,
    output logic          tx_near_empty,
    output logic          rx_near_full,
    output logic          rx_empty
);

    int rx_limit;
    int tx_limit;

    always_comb begin
        rx_limit      = rx_thr_sel ? RX_NF_SEL1 : RX_NF_SEL0;
        tx_limit      = tx_thr_sel ? TX_NE_SEL1 : TX_NE_SEL0;
        tx_full       = live && (int'(tx_count) == DEPTH);
        tx_near_empty = live && (int'(tx_count) <= tx_limit);
        rx_near_full  = live && (int'(rx_count) >= rx_limit);
        rx_empty      = live && (rx_count == '0);
    end

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int RX_NF_SEL0 = 6,
    parameter int RX_NF_SEL1 = 4,
    parameter int TX_NE_SEL0 = 2,
    parameter int TX_NE_SEL1 = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_spi_mode,
    input  logic        cfg_fifo_en,
    input  logic        cfg_periph_en,
    input  logic        cfg_wide,
    input  logic        rx_thr_sel,
    input  logic        tx_thr_sel,
    input  logic        host_wr,
    input  logic [15:0] host_wdata,
    input  logic        host_rd,
    output logic [15:0] host_rdata,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_data,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    output logic        rx_overrun,
    output logic        tx_full,
    output logic        tx_near_empty,
    output logic        rx_near_full,
    output logic        rx_empty
);

    localparam int CW = $clog2(DEPTH + 1);

    spi_cfg_t      cfg;
    fifo_state_e   state;
    logic          flush;
    logic          live;
    logic [1:0]    access_n;
    logic [1:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [7:0]    tx_b0, tx_h0, tx_h1, rx_h0, rx_h1;
    logic [CW-1:0] tx_count, rx_count;

    always_comb cfg = '{spi_mode: cfg_spi_mode, fifo_en: cfg_fifo_en, periph_en: cfg_periph_en};

    spi_fifo_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .flush(flush), .flags_live(live), .state(state)
    );

    always_comb begin
        access_n  = cfg_wide ? 2'd2 : 2'd1;
        tx_b0     = cfg_wide ? host_wdata[15:8] : host_wdata[7:0];
        tx_push_n = (host_wr && !flush && (int'(tx_count) + int'(access_n) <= DEPTH))
                    ? access_n : 2'd0;
        tx_pop_n  = (eng_tx_pop && !flush && (tx_count != '0)) ? 2'd1 : 2'd0;
        rx_push_n = (eng_rx_push && !flush && (int'(rx_count) < DEPTH)) ? 2'd1 : 2'd0;
        rx_pop_n  = (host_rd && !flush && (int'(rx_count) >= int'(access_n)))
                    ? access_n : 2'd0;
    end

    spi_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_n(tx_push_n), .push_b0(tx_b0), .push_b1(host_wdata[7:0]),
        .pop_n(tx_pop_n), .head0(tx_h0), .head1(tx_h1), .count(tx_count)
    );

    spi_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_n(rx_push_n), .push_b0(eng_rx_data), .push_b1(8'h00),
        .pop_n(rx_pop_n), .head0(rx_h0), .head1(rx_h1), .count(rx_count)
    );

    spi_fifo_flags #(
        .DEPTH(DEPTH), .RX_NF_SEL0(RX_NF_SEL0), .RX_NF_SEL1(RX_NF_SEL1),
        .TX_NE_SEL0(TX_NE_SEL0), .TX_NE_SEL1(TX_NE_SEL1)
    ) u_flags (
        .live(live), .rx_thr_sel(rx_thr_sel), .tx_thr_sel(tx_thr_sel),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_full(tx_full), .tx_near_empty(tx_near_empty),
        .rx_near_full(rx_near_full), .rx_empty(rx_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_overrun <= 1'b0;
        else        rx_overrun <= eng_rx_push && !flush && (int'(rx_count) == DEPTH);
    end

    always_comb begin
        eng_tx_data = tx_h0;
        host_rdata  = cfg_wide ? {rx_h0, rx_h1} : {8'h00, rx_h0};
    end

    // R9
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(eng_rx_push) && int'($past(rx_count)) == DEPTH));

    // R9
    overrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> (!rx_overrun || $past(eng_rx_push)));

    // R8
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACTIVE) |-> !(tx_full || tx_near_empty || rx_near_full || rx_empty));

    // R1
    full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_near_empty);

endmodule

// File: tb/test_spi_fifo_pair.sv
`timescale 1ns/1ps
module test_spi_fifo_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_spi_mode = 0, cfg_fifo_en = 0, cfg_periph_en = 0, cfg_wide = 0;
    logic        rx_thr_sel = 0, tx_thr_sel = 0;
    logic        host_wr = 0, host_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
    logic [15:0] host_wdata = '0;
    logic [7:0]  eng_rx_data = '0;
    logic [15:0] host_rdata;
    logic [7:0]  eng_tx_data;
    logic        rx_overrun, tx_full, tx_near_empty, rx_near_full, rx_empty;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    spi_fifo_pair i_spi_fifo_pair (
        .clk(clk), .rst_n(rst_n), .cfg_spi_mode(cfg_spi_mode), .cfg_fifo_en(cfg_fifo_en),
        .cfg_periph_en(cfg_periph_en), .cfg_wide(cfg_wide), .rx_thr_sel(rx_thr_sel),
        .tx_thr_sel(tx_thr_sel), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .eng_tx_pop(eng_tx_pop),
        .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .rx_overrun(rx_overrun), .tx_full(tx_full), .tx_near_empty(tx_near_empty),
        .rx_near_full(rx_near_full), .rx_empty(rx_empty)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input bit f, input bit ne, input bit nf, input bit e);
        chk(req, {tx_full, tx_near_empty, rx_near_full, rx_empty}, {f, ne, nf, e});
    endtask

    task automatic wr_tx(input logic [15:0] d);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pop_tx(output logic [7:0] d);
        d = eng_tx_data; eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic rd_rx(output logic [15:0] d);
        d = host_rdata; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_cfg(input bit m, input bit en, input bit pe);
        cfg_spi_mode = m; cfg_fifo_en = en; cfg_periph_en = pe;
        @(negedge clk);
    endtask

    task automatic t_por();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_flags("R6 flags after reset", 0, 0, 0, 0);
        chk("R6 overrun after reset", rx_overrun, 0);
    endtask

    task automatic t_enable();
        set_cfg(0, 1, 1);
        chk_flags("R8 flags after enable flush", 0, 1, 0, 1);
    endtask

    task automatic t_tx_narrow();
        logic [7:0] d;
        cfg_wide = 0; tx_thr_sel = 0;
        for (int i = 1; i <= 8; i++) begin
            wr_tx(16'(i));
            chk("R1 tx_full narrow", tx_full, int'(i == 8));
            chk("R3 tx_near_empty sel0", tx_near_empty, int'(i <= 2));
        end
        wr_tx(16'h0099);
        chk("R10 write to full", tx_full, 1);
        pop_tx(d);
        chk("R5 first byte", d, 1);
        chk("R1 full clears", tx_full, 0);
        wr_tx(16'h0077);
        for (int i = 2; i <= 9; i++) begin
            pop_tx(d);
            chk("R10 order after dropped write", d, (i == 9) ? 8'h77 : i);
        end
        chk("R3 drained", tx_near_empty, 1);
    endtask

    task automatic t_tx_wide();
        logic [7:0] d;
        cfg_wide = 1; tx_thr_sel = 1;
        for (int k = 1; k <= 4; k++) begin
            wr_tx({4'hA, 4'(k), 4'hB, 4'(k)});
            chk("R3 tx_near_empty sel1 wide", tx_near_empty, int'(2 * k <= 4));
            chk("R1 tx_full wide", tx_full, int'(k == 4));
            if (k == 2) begin
                tx_thr_sel = 0; #1;
                chk("R3 sel0 at 4 bytes", tx_near_empty, 0);
                tx_thr_sel = 1; #1;
                chk("R3 sel1 at 4 bytes", tx_near_empty, 1);
            end
        end
        wr_tx(16'hDEAD);
        for (int k = 1; k <= 4; k++) begin
            pop_tx(d);
            chk("R5 high byte first", d, {4'hA, 4'(k)});
            pop_tx(d);
            chk("R5 low byte second", d, {4'hB, 4'(k)});
        end
        chk("R3 empty tx", tx_near_empty, 1);
    endtask

    task automatic t_rx_narrow();
        logic [15:0] d;
        cfg_wide = 0; rx_thr_sel = 0;
        for (int i = 0; i < 8; i++) begin
            push_rx(8'(8'h10 + i));
            chk("R2 rx_near_full sel0", rx_near_full, int'(i + 1 >= 6));
            chk("R4 rx_empty with data", rx_empty, 0);
        end
        chk("R9 no overrun on fit", rx_overrun, 0);
        push_rx(8'hEE);
        chk("R9 overrun pulse", rx_overrun, 1);
        @(negedge clk);
        chk("R9 overrun one cycle", rx_overrun, 0);
        rx_thr_sel = 1;
        for (int i = 0; i < 8; i++) begin
            rd_rx(d);
            chk("R4 narrow read data", d, {8'h00, 8'(8'h10 + i)});
            chk("R2 rx_near_full sel1", rx_near_full, int'(7 - i >= 4));
        end
        chk("R4 rx_empty after drain", rx_empty, 1);
    endtask

    task automatic t_rx_wide();
        logic [15:0] d;
        cfg_wide = 1; rx_thr_sel = 1;
        push_rx(8'hC1); push_rx(8'hC2); push_rx(8'hC3);
        chk("R2 three bytes sel1", rx_near_full, 0);
        push_rx(8'hC4);
        chk("R2 four bytes sel1", rx_near_full, 1);
        rd_rx(d);
        chk("R4 wide read", d, 16'hC1C2);
        push_rx(8'hC5);
        rd_rx(d);
        chk("R4 wide read 2", d, 16'hC3C4);
        rd_rx(d);
        chk("R10 short wide read keeps byte", rx_empty, 0);
        cfg_wide = 0; #1;
        chk("R10 byte still at head", host_rdata, 16'h00C5);
        rd_rx(d);
        chk("R4 empty after last", rx_empty, 1);
    endtask

    task automatic t_flush();
        logic [7:0] d;
        cfg_wide = 0;
        wr_tx(16'h0011); wr_tx(16'h0022); wr_tx(16'h0033);
        push_rx(8'h44); push_rx(8'h55);
        set_cfg(1, 1, 1);
        chk_flags("R7 flush on mode change", 0, 1, 0, 1);
        wr_tx(16'h005A);
        pop_tx(d);
        chk("R7 old tx data gone", d, 8'h5A);
        push_rx(8'h66);
        set_cfg(1, 1, 0);
        chk_flags("R7 flush on enable change", 0, 1, 0, 1);
    endtask

    task automatic t_disable();
        set_cfg(1, 0, 0);
        chk_flags("R8 flags with queue mode off", 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) push_rx(8'(i));
        chk_flags("R8 flags held with data", 0, 0, 0, 0);
        set_cfg(1, 1, 0);
        chk_flags("R8 re-enable flush", 0, 1, 0, 1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        t_por();
        t_enable();
        t_tx_narrow();
        t_tx_wide();
        t_rx_narrow();
        t_rx_wide();
        t_flush();
        t_disable();
        summary();
    end

endmodule